// File: doc/BRIEF.md
# Registered Command/Address Fan-Out Buffer

This block sits between a memory controller and a row of memory devices on a registered module. Every rising clock edge it captures a command/address bus, a group of chip selects, two clock-enable lines and two on-die-termination lines. One cycle later it drives them out as two output copies, an A side and a B side, so that each side can feed half of the devices. The command/address bus is always copied one-to-two.

The chip-select path has two layouts. A strap input chooses the layout, and the block samples the strap only while reset is held. A small mode machine holds the chosen layout in one of two states. `ST_DUAL` is entered when the strap reads high during reset, and high is the strap's default. In this state two selects each drive an A-side and a B-side copy. `ST_QUAD` is entered when the strap reads low during reset. In this state four selects map one-to-one onto the four A-side outputs. Each reset edge makes the transition RESET→`ST_DUAL` or RESET→`ST_QUAD`. Outside reset the state holds and no transition occurs.

An output-disable input, captured like the data, makes every output show its idle value in the next cycle. Idle means chip selects high (inactive) and every other output low.

Top module: `ca_fanout_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, after that edge all of `cs_a` and `cs_b` are 1 and `ca_a`, `ca_b`, `cke_a`, `cke_b`, `odt_a`, `odt_b` are 0.
- R2: Each bit of `ca_in` captured at a rising edge with `out_off` low appears on both `ca_a` and `ca_b` after that edge and no sooner. The latency is exactly one clock.
- R3: In `ST_DUAL`, after an edge with `out_off` low, `cs_a[1:0]` and `cs_b[1:0]` both equal the captured `cs_in[1:0]` and `cs_a[3:2]` is `2'b11`. In this mode `cs_in[3:2]` has no effect on any output.
- R4: In `ST_QUAD`, after an edge with `out_off` low, `cs_a[3:0]` equals the captured `cs_in[3:0]` bit for bit (`cs_a[i]` from `cs_in[i]`) and `cs_b` is `2'b11`.
- R5: `qcs_strap` is read only at edges where `rst_n` is low, and high selects `ST_DUAL` while low selects `ST_QUAD`. A change of the strap while `rst_n` is high does not change the chip-select layout.
- R6: `cke_in[1:0]` and `odt_in[1:0]` are registered and appear on both `cke_a`/`cke_b` and `odt_a`/`odt_b` one clock later.
- R7: When `out_off` is high at a rising edge, after that edge every output takes its idle value, whatever the data inputs hold. The idle values are chip selects 1 and all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| qcs_strap | input | 1 | Chip-select layout strap: 1 = two duplicated selects, 0 = four one-to-one selects |
| out_off | input | 1 | Output disable, active high, registered |
| ca_in | input | 28 | Command/address bus |
| cs_in | input | 4 | Chip selects, active low |
| cke_in | input | 2 | Clock enables |
| odt_in | input | 2 | On-die-termination controls |
| ca_a | output | 28 | Command/address, A side |
| ca_b | output | 28 | Command/address, B side |
| cs_a | output | 4 | Chip selects, A side |
| cs_b | output | 2 | Chip selects, B side |
| cke_a | output | 2 | Clock enables, A side |
| cke_b | output | 2 | Clock enables, B side |
| odt_a | output | 2 | Termination controls, A side |
| odt_b | output | 2 | Termination controls, B side |

## Verification
The mode state is the only internal state beyond the data flops. If it is wrong, the chip-select outputs show it at the first edge after reset. `cs_b` follows `cs_in[1:0]` where it should sit at `2'b11`, or `cs_a[3:2]` follows the upper inputs where it should stay high. A data flop that captures on the wrong edge or misses the disable shows up on the very next cycle as a mismatch against the inputs driven one cycle earlier. Any difference between the A and B copies is visible in the same cycle.

// File: rtl/ca_fanout_pkg.sv
package ca_fanout_pkg;

    localparam int CA_W   = 28;
    localparam int CS_LO  = 2;
    localparam int CS_ALL = 4;
    localparam int CTL_W  = 2;

    typedef enum logic [0:0] {
        ST_DUAL = 1'b0,
        ST_QUAD = 1'b1
    } cs_mode_t;

endpackage

// File: rtl/ca_mode_fsm.sv
module ca_mode_fsm
    import ca_fanout_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strap,
    output cs_mode_t mode,
    output logic     quad
);

    cs_mode_t state;

    // State register: the strap is read only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= strap ? ST_DUAL : ST_QUAD;
        end else begin
            state <= state;
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_DUAL: quad = 1'b0;
            ST_QUAD: quad = 1'b1;
            default: quad = 1'b0;
        endcase
    end

    assign mode = state;

    // R5: the layout never changes outside reset
    a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(state));

endmodule

// File: rtl/ca_cs_route.sv
module ca_cs_route #(
    parameter int N_LO  = 2,
    parameter int N_ALL = 4
) (
    input  logic             quad,
    input  logic [N_ALL-1:0] cs_in,
    output logic [N_ALL-1:0] nxt_a,
    output logic [N_LO-1:0]  nxt_b
);

    for (genvar i = 0; i < N_LO; i++) begin : g_low
        assign nxt_a[i] = cs_in[i];
        assign nxt_b[i] = quad ? 1'b1 : cs_in[i];
    end

    for (genvar j = N_LO; j < N_ALL; j++) begin : g_high
        assign nxt_a[j] = quad ? cs_in[j] : 1'b1;
    end

endmodule

// File: rtl/ca_dup_reg.sv
module ca_dup_reg #(
    parameter int         W    = 8,
    parameter logic       IDLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         off,
    input  logic [W-1:0] d,
    output logic [W-1:0] qa,
    output logic [W-1:0] qb
);

    always_ff @(posedge clk) begin
        if (!rst_n || off) begin
            qa <= {W{IDLE}};
            qb <= {W{IDLE}};
        end else begin
            qa <= d;
            qb <= d;
        end
    end

endmodule

// File: rtl/ca_fanout_reg.sv
module ca_fanout_reg
    import ca_fanout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qcs_strap,
    input  logic              out_off,
    input  logic [CA_W-1:0]   ca_in,
    input  logic [CS_ALL-1:0] cs_in,
    input  logic [CTL_W-1:0]  cke_in,
    input  logic [CTL_W-1:0]  odt_in,
    output logic [CA_W-1:0]   ca_a,
    output logic [CA_W-1:0]   ca_b,
    output logic [CS_ALL-1:0] cs_a,
    output logic [CS_LO-1:0]  cs_b,
    output logic [CTL_W-1:0]  cke_a,
    output logic [CTL_W-1:0]  cke_b,
    output logic [CTL_W-1:0]  odt_a,
    output logic [CTL_W-1:0]  odt_b
);

    cs_mode_t          mode;
    logic              quad;
    logic [CS_ALL-1:0] cs_nxt_a;
    logic [CS_LO-1:0]  cs_nxt_b;

    ca_mode_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (qcs_strap),
        .mode  (mode),
        .quad  (quad)
    );

    ca_cs_route #(.N_LO(CS_LO), .N_ALL(CS_ALL)) u_route (
        .quad  (quad),
        .cs_in (cs_in),
        .nxt_a (cs_nxt_a),
        .nxt_b (cs_nxt_b)
    );

    ca_dup_reg #(.W(CA_W), .IDLE(1'b0)) u_ca (
        .clk (clk), .rst_n (rst_n), .off (out_off),
        .d (ca_in), .qa (ca_a), .qb (ca_b)
    );

    ca_dup_reg #(.W(CTL_W), .IDLE(1'b0)) u_cke (
        .clk (clk), .rst_n (rst_n), .off (out_off),
        .d (cke_in), .qa (cke_a), .qb (cke_b)
    );

    ca_dup_reg #(.W(CTL_W), .IDLE(1'b0)) u_odt (
        .clk (clk), .rst_n (rst_n), .off (out_off),
        .d (odt_in), .qa (odt_a), .qb (odt_b)
    );

    // Chip-select register, idle high
    always_ff @(posedge clk) begin
        if (!rst_n || out_off) begin
            cs_a <= '1;
            cs_b <= '1;
        end else begin
            cs_a <= cs_nxt_a;
            cs_b <= cs_nxt_b;
        end
    end

    // R2: one-cycle copy onto both sides
    a_r2_ca_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(out_off)) |-> (ca_a == $past(ca_in) && ca_b == $past(ca_in)));

    // R4: unused B-side selects stay inactive in quad layout
    a_r4_quad_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode == ST_QUAD) |-> (cs_b == '1));

    // R3: duplicated selects in dual layout
    a_r3_dual_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(out_off) && mode == ST_DUAL)
        |-> (cs_a == {2'b11, $past(cs_in[1:0])} && cs_b == $past(cs_in[1:0])));

    // R7: disable forces idle values
    a_r7_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(out_off)) |-> (ca_a == '0 && cs_a == '1 && cke_b == '0 && odt_a == '0));

    // R6: control lines follow one cycle later
    a_r6_ctl_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(out_off)) |-> (cke_b == $past(cke_in) && odt_b == $past(odt_in)));

endmodule

// File: tb/ca_fanout_reg_tb.sv
module ca_fanout_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qcs_strap = 1'b1;
    logic        out_off = 1'b0;
    logic [27:0] ca_in = '0;
    logic [3:0]  cs_in = 4'hF;
    logic [1:0]  cke_in = '0;
    logic [1:0]  odt_in = '0;
    logic [27:0] ca_a, ca_b;
    logic [3:0]  cs_a;
    logic [1:0]  cs_b, cke_a, cke_b, odt_a, odt_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ca_fanout_reg u_dut (
        .clk (clk), .rst_n (rst_n), .qcs_strap (qcs_strap), .out_off (out_off),
        .ca_in (ca_in), .cs_in (cs_in), .cke_in (cke_in), .odt_in (odt_in),
        .ca_a (ca_a), .ca_b (ca_b), .cs_a (cs_a), .cs_b (cs_b),
        .cke_a (cke_a), .cke_b (cke_b), .odt_a (odt_a), .odt_b (odt_b)
    );

    // vector: {ca[28], cs[4], cke[2], odt[2], off[1]}
    localparam logic [36:0] VEC [8] = '{
        {28'h0000000, 4'hF, 2'b00, 2'b00, 1'b0},
        {28'hFFFFFFF, 4'h0, 2'b11, 2'b11, 1'b0},
        {28'hA5A5A5A, 4'hE, 2'b01, 2'b10, 1'b0},
        {28'h5A5A5A5, 4'hD, 2'b10, 2'b01, 1'b0},
        {28'h1234567, 4'h3, 2'b11, 2'b00, 1'b0},
        {28'h89ABCDE, 4'hC, 2'b00, 2'b11, 1'b1},
        {28'h0000001, 4'h6, 2'b01, 2'b01, 1'b0},
        {28'h8000000, 4'h9, 2'b10, 2'b10, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, check after the following rising edge.
    task automatic apply(input logic [36:0] v, input bit quad);
        logic [27:0] e_ca;
        logic [3:0]  e_csa;
        logic [1:0]  e_csb, e_cke, e_odt;
        @(negedge clk);
        ca_in = v[36:9]; cs_in = v[8:5]; cke_in = v[4:3]; odt_in = v[2:1]; out_off = v[0];
        @(negedge clk);
        if (v[0]) begin
            e_ca = '0; e_csa = 4'hF; e_csb = 2'b11; e_cke = '0; e_odt = '0;
        end else begin
            e_ca = v[36:9]; e_cke = v[4:3]; e_odt = v[2:1];
            if (quad) begin
                e_csa = v[8:5]; e_csb = 2'b11;
            end else begin
                e_csa = {2'b11, v[6:5]}; e_csb = v[6:5];
            end
        end
        if (v[0]) begin
            chk("R7 ca_a idle", {4'h0, ca_a}, {4'h0, e_ca});
            chk("R7 cs idle", {26'h0, cs_a, cs_b}, {26'h0, e_csa, e_csb});
            chk("R7 ctl idle", {24'h0, cke_a, cke_b, odt_a, odt_b}, {24'h0, e_cke, e_cke, e_odt, e_odt});
        end else begin
            chk("R2 ca both sides", {ca_a, 4'h0} ^ {ca_b, 4'h0}, 32'h0);
            chk("R2 ca value", {4'h0, ca_a}, {4'h0, e_ca});
            chk(quad ? "R4 quad cs" : "R3 dual cs", {26'h0, cs_a, cs_b}, {26'h0, e_csa, e_csb});
            chk("R6 cke/odt", {24'h0, cke_a, cke_b, odt_a, odt_b}, {24'h0, e_cke, e_cke, e_odt, e_odt});
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0; qcs_strap = strap;
        ca_in = '1; cs_in = 4'h0; cke_in = 2'b11; odt_in = 2'b11; out_off = 1'b0;
        repeat (2) @(negedge clk);
        // R1: idle values while reset is held
        chk("R1 ca reset", {4'h0, ca_a | ca_b}, 32'h0);
        chk("R1 cs reset", {26'h0, cs_a, cs_b}, {26'h0, 4'hF, 2'b11});
        chk("R1 ctl reset", {24'h0, cke_a, cke_b, odt_a, odt_b}, 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        // Dual layout, table walk
        do_reset(1'b1);
        for (int i = 0; i < 8; i++) apply(VEC[i], 1'b0);

        // R3: upper inputs ignored in dual layout
        apply({28'h0F0F0F0, 4'b0011, 2'b00, 2'b00, 1'b0}, 1'b0);
        apply({28'h0F0F0F0, 4'b1111, 2'b00, 2'b00, 1'b0}, 1'b0);

        // R5: strap change outside reset has no effect
        @(negedge clk); qcs_strap = 1'b0;
        apply({28'h3C3C3C3, 4'b0101, 2'b01, 2'b10, 1'b0}, 1'b0);
        apply({28'h3C3C3C4, 4'b1010, 2'b10, 2'b01, 1'b0}, 1'b0);

        // Quad layout, table walk
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) apply(VEC[i], 1'b1);

        // R4: each select alone
        for (int k = 0; k < 4; k++) begin
            logic [3:0] one_low;
            one_low = ~(4'b0001 << k);
            apply({28'h0000000, one_low, 2'b00, 2'b00, 1'b0}, 1'b1);
        end

        // R5: strap back high outside reset, quad layout stays
        @(negedge clk); qcs_strap = 1'b1;
        apply({28'hABCDEF0, 4'b0110, 2'b11, 2'b11, 1'b0}, 1'b1);

        // R7: back-to-back disable then resume
        apply({28'hFFFFFFF, 4'h0, 2'b11, 2'b11, 1'b1}, 1'b1);
        apply({28'hFFFFFFF, 4'h0, 2'b11, 2'b11, 1'b1}, 1'b1);
        apply({28'h7777777, 4'h5, 2'b01, 2'b01, 1'b0}, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule